// File: doc/BRIEF.md
# Nested Active Interrupt Tracker

This block keeps the active-interrupt state of a single processor in an interrupt controller. When the processor reads its acknowledge register, the surrounding logic offers the best pending interrupt ID and that ID's priority. The tracker admits the ID only if its priority is strictly more urgent than the priority now running. It then makes the ID the running interrupt, records the displaced running ID as that ID's predecessor, and asks for the pending flag to be cleared. The response is the admitted ID, or the spurious code 1023.

An end-of-interrupt write names one interrupt to retire. If that ID is the running one, its predecessor becomes running again. If the ID sits deeper in the nesting, a small walker follows the predecessor links from the running ID, one link per cycle. When it finds the link that points at the retired ID, it splices that ID out. Completion of a level-sensitive source whose line is still raised produces a request to set it pending again. Priorities are not stored here: the running priority is looked up through a pair of ports.

Acknowledge requests and completion writes each enter on a valid/ready pair, and a transfer takes place on a clock edge where both are high. Ready drops for both while a chain walk is in progress. It also drops for acknowledge whenever a completion is offered in the same cycle. A held request waits and is never lost. The acknowledge response and the pending-clear and pending-set requests are single-cycle pulses that cannot be stalled.

Top module: `nest_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, the block is not busy, both ready signals are high, and every predecessor link holds 1023.
- R2: An accepted acknowledge answers 1023 one cycle later, with no pending-clear and no change of running ID, when the offered ID is not below NUM_IRQ (1023 means nothing pending) or its priority is not strictly below the running priority.
- R3: Otherwise the response is the offered ID. Together with it comes a pending-clear pulse carrying that ID, and the ID becomes running at the same edge.
- R4: `lkp_id` always shows the running ID. The running priority is 0x100 when the running ID is 1023 and otherwise zero-extended `lkp_prio`.
- R5: The completed ID is bits 9:0 of `eoi_data`, and upper bits are ignored. An ID not below NUM_IRQ, 1023 included, changes nothing.
- R6: A completion accepted while the running ID is 1023 changes nothing and sends no pending-set request.
- R7: Completing the running ID makes its recorded predecessor running, or 1023 if it had none, at the accepting edge.
- R8: Completing an active ID that is not running removes it from the nesting chain and leaves the running ID unchanged. The block is busy for one cycle per link examined, and both ready signals are low while busy. A later completion of the ID above it then skips it.
- R9: An accepted valid completion while something is running, with `lvl_repend` high, gives a one-cycle `pend_set_valid` pulse with the completed ID on the next cycle.
- R10: When acknowledge and completion are both offered in one idle cycle, the completion is taken first and `ack_ready` is low. The acknowledge is taken on the following edge and judged against the updated running priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Acknowledge request offered |
| ack_ready | output | 1 | Acknowledge request can be taken |
| pend_id | input | 10 | Highest pending ID (1023 = none) |
| pend_prio | input | 8 | Priority of `pend_id` (lower is more urgent) |
| ack_rsp_valid | output | 1 | Acknowledge response pulse |
| ack_rsp_id | output | 10 | Granted ID or 1023 |
| pend_clr_valid | output | 1 | Clear-pending request pulse |
| pend_clr_id | output | 10 | ID whose pending state is to be cleared |
| eoi_valid | input | 1 | Completion write offered |
| eoi_ready | output | 1 | Completion write can be taken |
| eoi_data | input | 32 | Completion write data, ID in bits 9:0 |
| lvl_repend | input | 1 | Completed ID is level, enabled, targeted and still raised |
| pend_set_valid | output | 1 | Set-pending request pulse |
| pend_set_id | output | 10 | ID to set pending again |
| lkp_id | output | 10 | Priority lookup address (the running ID) |
| lkp_prio | input | 8 | Priority returned for `lkp_id` |
| run_id | output | 10 | Running interrupt ID (1023 = idle) |
| run_prio | output | 9 | Running priority (0x100 when idle) |
| busy | output | 1 | Chain walk in progress |

## Verification
An acknowledge and a completion can both be offered on the same idle cycle. The bench drives both together while an interrupt is running. It first confirms that `ack_ready` is low while `eoi_ready` is high. On the next cycle it checks that the running interrupt was retired and that no acknowledge response appeared. On the cycle after that, the held acknowledge must be granted against the idle priority. The bench also completes IDs in the middle and at the bottom of a three-deep chain, and completes an ID that is not in the chain at all. In each case it then retires the remaining IDs, which shows that the links were spliced correctly.

// File: rtl/nat_pkg.sv
package nat_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = '1;
  typedef enum logic {W_IDLE, W_RUN} walk_st_e;
endpackage

// File: rtl/nat_link_table.sv
module nat_link_table
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ID_W-1:0]  wdata,
  input  logic [IDX_W-1:0] ra_addr,
  output logic [ID_W-1:0]  ra_data,
  input  logic [IDX_W-1:0] rb_addr,
  output logic [ID_W-1:0]  rb_data
);
  logic [ID_W-1:0] link_q [NUM_IRQ];

  // one predecessor entry per interrupt ID
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) link_q[g] <= NONE_ID;
      else if (we && waddr == IDX_W'(g)) link_q[g] <= wdata;
    end
  end

  assign ra_data = (int'(ra_addr) < NUM_IRQ) ? link_q[ra_addr] : NONE_ID;
  assign rb_data = (int'(rb_addr) < NUM_IRQ) ? link_q[rb_addr] : NONE_ID;
endmodule

// File: rtl/nat_walker.sv
module nat_walker
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ID_W-1:0]  start_cur,
  input  logic [ID_W-1:0]  start_tgt,
  input  logic [ID_W-1:0]  cur_link,
  input  logic [ID_W-1:0]  tgt_link,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] tgt_idx,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [ID_W-1:0]  wr_data
);
  localparam int STEP_W = $clog2(NUM_IRQ + 1);

  walk_st_e          st_q;
  logic [ID_W-1:0]   cur_q, tgt_q;
  logic [STEP_W-1:0] steps_q;
  logic              hit, dead_end;

  assign hit      = (st_q == W_RUN) && (cur_link == tgt_q) && (cur_link != NONE_ID);
  assign dead_end = (cur_link == NONE_ID) || (steps_q == STEP_W'(NUM_IRQ));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      cur_q   <= NONE_ID;
      tgt_q   <= NONE_ID;
      steps_q <= '0;
    end else if (st_q == W_IDLE) begin
      if (start) begin
        st_q    <= W_RUN;
        cur_q   <= start_cur;
        tgt_q   <= start_tgt;
        steps_q <= '0;
      end
    end else if (hit || dead_end) begin
      st_q <= W_IDLE;
    end else begin
      cur_q   <= cur_link;
      steps_q <= steps_q + 1'b1;
    end
  end

  assign busy    = (st_q == W_RUN);
  assign cur_idx = cur_q[IDX_W-1:0];
  assign tgt_idx = tgt_q[IDX_W-1:0];
  assign wr_en   = hit;
  assign wr_addr = cur_q[IDX_W-1:0];
  assign wr_data = tgt_link;
endmodule

// File: rtl/nest_tracker.sv
module nest_tracker
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              ack_rsp_valid,
  output logic [ID_W-1:0]   ack_rsp_id,
  output logic              pend_clr_valid,
  output logic [ID_W-1:0]   pend_clr_id,
  input  logic              eoi_valid,
  output logic              eoi_ready,
  input  logic [DATA_W-1:0] eoi_data,
  input  logic              lvl_repend,
  output logic              pend_set_valid,
  output logic [ID_W-1:0]   pend_set_id,
  output logic [ID_W-1:0]   lkp_id,
  input  logic [PRIO_W-1:0] lkp_prio,
  output logic [ID_W-1:0]   run_id,
  output logic [PRIO_W:0]   run_prio,
  output logic              busy
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W:0] NUM_L = (ID_W+1)'(NUM_IRQ);

  logic [ID_W-1:0]  run_q, eoi_id, ra_data, rb_data, w_wdata;
  logic [IDX_W-1:0] w_cur, w_tgt, w_waddr, ra_addr;
  logic             ack_fire, eoi_fire, pend_ok, eoi_ok, w_we, walk_start;
  logic             unused_hi;

  assign eoi_id    = eoi_data[ID_W-1:0];
  assign unused_hi = &{1'b0, eoi_data[DATA_W-1:ID_W]};

  assign lkp_id   = run_q;
  assign run_id   = run_q;
  assign run_prio = (run_q == NONE_ID) ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, lkp_prio};

  // completion has precedence over acknowledge; walk blocks both
  assign eoi_ready = !busy;
  assign ack_ready = !busy && !eoi_valid;
  assign ack_fire  = ack_valid && ack_ready;
  assign eoi_fire  = eoi_valid && eoi_ready;

  assign pend_ok    = ({1'b0, pend_id} < NUM_L) && ({1'b0, pend_prio} < run_prio);
  assign eoi_ok     = eoi_fire && ({1'b0, eoi_id} < NUM_L) && (run_q != NONE_ID);
  assign walk_start = eoi_ok && (eoi_id != run_q);

  assign ra_addr = busy ? w_cur : run_q[IDX_W-1:0];

  nat_link_table #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) links_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (w_we || (ack_fire && pend_ok)),
    .waddr   (w_we ? w_waddr : pend_id[IDX_W-1:0]),
    .wdata   (w_we ? w_wdata : run_q),
    .ra_addr (ra_addr),
    .ra_data (ra_data),
    .rb_addr (w_tgt),
    .rb_data (rb_data)
  );

  nat_walker #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) walk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .start_cur (run_q),
    .start_tgt (eoi_id),
    .cur_link  (ra_data),
    .tgt_link  (rb_data),
    .cur_idx   (w_cur),
    .tgt_idx   (w_tgt),
    .busy      (busy),
    .wr_en     (w_we),
    .wr_addr   (w_waddr),
    .wr_data   (w_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q          <= NONE_ID;
      ack_rsp_valid  <= 1'b0;
      ack_rsp_id     <= NONE_ID;
      pend_clr_valid <= 1'b0;
      pend_clr_id    <= NONE_ID;
      pend_set_valid <= 1'b0;
      pend_set_id    <= NONE_ID;
    end else begin
      if (ack_fire && pend_ok)                run_q <= pend_id;
      else if (eoi_ok && eoi_id == run_q)     run_q <= ra_data;
      ack_rsp_valid  <= ack_fire;
      ack_rsp_id     <= pend_ok ? pend_id : NONE_ID;
      pend_clr_valid <= ack_fire && pend_ok;
      pend_clr_id    <= pend_id;
      pend_set_valid <= eoi_ok && lvl_repend;
      pend_set_id    <= eoi_id;
    end
  end
endmodule

// File: rtl/nat_checker.sv
module nat_checker
  import nat_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_valid,
  input logic              ack_ready,
  input logic [ID_W-1:0]   pend_id,
  input logic [PRIO_W-1:0] pend_prio,
  input logic              ack_rsp_valid,
  input logic [ID_W-1:0]   ack_rsp_id,
  input logic              pend_clr_valid,
  input logic [ID_W-1:0]   pend_clr_id,
  input logic              eoi_valid,
  input logic              eoi_ready,
  input logic [DATA_W-1:0] eoi_data,
  input logic              pend_set_valid,
  input logic [ID_W-1:0]   run_id,
  input logic [PRIO_W:0]   run_prio,
  input logic              busy
);
  // R2: refused acknowledge answers spurious and keeps the running ID
  a_r2_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && !((int'(pend_id) < NUM_IRQ) && ({1'b0, pend_prio} < run_prio)))
    |=> (ack_rsp_valid && ack_rsp_id == NONE_ID && !pend_clr_valid && $stable(run_id)));

  // R3: granted acknowledge makes the ID running
  a_r3_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && (int'(pend_id) < NUM_IRQ) && ({1'b0, pend_prio} < run_prio))
    |=> (run_id == $past(pend_id) && pend_clr_valid && ack_rsp_id == $past(pend_id)));

  // R3: a clear request always comes with a matching response
  a_r3_clr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_valid |-> (ack_rsp_valid && ack_rsp_id == pend_clr_id));

  // R5: out-of-range completion changes nothing
  a_r5_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && int'(eoi_data[ID_W-1:0]) >= NUM_IRQ)
    |=> ($stable(run_id) && !busy && !pend_set_valid));

  // R6: completion while idle is ignored
  a_r6_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && run_id == NONE_ID)
    |=> (run_id == NONE_ID && !busy && !pend_set_valid));

  // R8: the running ID holds while the chain is walked
  a_r8_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_id));
endmodule

bind nest_tracker nat_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
  .pend_id(pend_id), .pend_prio(pend_prio), .ack_rsp_valid(ack_rsp_valid),
  .ack_rsp_id(ack_rsp_id), .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id),
  .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_data(eoi_data),
  .pend_set_valid(pend_set_valid), .run_id(run_id), .run_prio(run_prio), .busy(busy)
);

// File: tb/nest_tracker_tb_top.sv
module nest_tracker_tb_top;
  localparam int NONE = 1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_valid = 1'b0, eoi_valid = 1'b0, lvl_repend = 1'b0;
  logic [9:0]  pend_id = 10'h3FF;
  logic [7:0]  pend_prio = 8'hFF;
  logic [31:0] eoi_data = '0;
  logic        ack_ready, ack_rsp_valid, pend_clr_valid, eoi_ready, pend_set_valid, busy;
  logic [9:0]  ack_rsp_id, pend_clr_id, pend_set_id, lkp_id, run_id;
  logic [8:0]  run_prio;
  logic [7:0]  lkp_prio;
  logic [7:0]  prio_tb [64];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign lkp_prio = (lkp_id < 10'd64) ? prio_tb[lkp_id[5:0]] : 8'h00;

  nest_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .pend_id(pend_id), .pend_prio(pend_prio), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_id(ack_rsp_id), .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_data(eoi_data),
    .lvl_repend(lvl_repend), .pend_set_valid(pend_set_valid), .pend_set_id(pend_set_id),
    .lkp_id(lkp_id), .lkp_prio(lkp_prio), .run_id(run_id), .run_prio(run_prio), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_ack(input int id, input int exp, input string req);
    @(negedge clk);
    ack_valid = 1'b1; pend_id = 10'(id);
    pend_prio = (id < 64) ? prio_tb[id] : 8'h00;
    @(negedge clk);
    ack_valid = 1'b0; pend_id = 10'h3FF;
    chk({req, " rsp_valid"}, int'(ack_rsp_valid), 1);
    chk({req, " rsp_id"}, int'(ack_rsp_id), exp);
    chk({req, " clr_valid"}, int'(pend_clr_valid), (exp != NONE) ? 1 : 0);
  endtask

  task automatic do_eoi(input logic [31:0] d, input bit rep);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_data = d; lvl_repend = rep;
    @(negedge clk);
    eoi_valid = 1'b0; lvl_repend = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 run_id", int'(run_id), NONE);
    chk("R1 run_prio", int'(run_prio), 'h100);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ready", int'({ack_ready, eoi_ready}), 3);
  endtask

  task automatic t_refuse();
    do_ack(NONE, NONE, "R2 nothing pending");
    do_ack(5, 5, "R3 grant 5");
    chk("R3 run_id", int'(run_id), 5);
    chk("R3 clr_id", int'(pend_clr_id), 5);
    chk("R4 run_prio", int'(run_prio), 'h40);
    chk("R4 lkp_id", int'(lkp_id), 5);
    do_ack(3, NONE, "R2 lower urgency");
    do_ack(12, NONE, "R2 equal priority");
    chk("R2 run kept", int'(run_id), 5);
  endtask

  task automatic t_mid_unlink();
    do_ack(7, 7, "R3 grant 7");
    do_ack(9, 9, "R3 grant 9");
    do_eoi(32'h0000_03FF, 1'b0);
    chk("R5 id 1023 ignored", int'(run_id), 9);
    do_eoi(32'h0000_0040, 1'b0);
    chk("R5 id 64 ignored", int'(run_id), 9);
    do_eoi(32'h0000_0007, 1'b0);
    chk("R8 busy", int'(busy), 1);
    chk("R8 ready low", int'({ack_ready, eoi_ready}), 0);
    wait_idle();
    chk("R8 run kept", int'(run_id), 9);
    do_eoi(32'hABCD_E009, 1'b0);
    chk("R5 R8 skip to 5", int'(run_id), 5);
    chk("R4 prio 5", int'(run_prio), 'h40);
  endtask

  task automatic t_repend_idle();
    do_eoi(32'd5, 1'b1);
    chk("R7 idle again", int'(run_id), NONE);
    chk("R9 set pulse", int'(pend_set_valid), 1);
    chk("R9 set id", int'(pend_set_id), 5);
    do_eoi(32'd5, 1'b1);
    chk("R6 idle ignored", int'(run_id), NONE);
    chk("R6 no set", int'(pend_set_valid), 0);
    chk("R4 idle prio", int'(run_prio), 'h100);
  endtask

  task automatic t_same_cycle();
    do_ack(5, 5, "R10 setup 5");
    @(negedge clk);
    ack_valid = 1'b1; pend_id = 10'd9; pend_prio = prio_tb[9];
    eoi_valid = 1'b1; eoi_data = 32'd5;
    #1;
    chk("R10 ack held off", int'(ack_ready), 0);
    chk("R10 eoi ready", int'(eoi_ready), 1);
    @(negedge clk);
    eoi_valid = 1'b0;
    chk("R10 eoi first", int'(run_id), NONE);
    chk("R10 no ack yet", int'(ack_rsp_valid), 0);
    @(negedge clk);
    ack_valid = 1'b0;
    chk("R10 ack later", int'(ack_rsp_id), 9);
    chk("R10 run 9", int'(run_id), 9);
    do_eoi(32'd9, 1'b0);
    chk("R7 back idle", int'(run_id), NONE);
  endtask

  task automatic t_not_found();
    do_ack(5, 5, "R3 grant 5b");
    do_ack(9, 9, "R3 grant 9b");
    do_eoi(32'd7, 1'b0);
    @(negedge clk);
    chk("R8 two-link walk", int'(busy), 1);
    wait_idle();
    chk("R8 absent id", int'(run_id), 9);
    do_eoi(32'd9, 1'b0);
    chk("R7 chain intact", int'(run_id), 5);
    do_eoi(32'd5, 1'b0);
    chk("R7 chain end", int'(run_id), NONE);
  endtask

  task automatic t_bottom_unlink();
    do_ack(5, 5, "R3 grant 5c");
    do_ack(7, 7, "R3 grant 7c");
    do_ack(9, 9, "R3 grant 9c");
    do_eoi(32'd5, 1'b0);
    wait_idle();
    chk("R8 bottom run kept", int'(run_id), 9);
    do_eoi(32'd9, 1'b0);
    chk("R7 to 7", int'(run_id), 7);
    do_eoi(32'd7, 1'b0);
    chk("R8 bottom gone", int'(run_id), NONE);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prio_tb[i] = 8'hF0;
    prio_tb[3] = 8'h50; prio_tb[5] = 8'h40; prio_tb[7] = 8'h20;
    prio_tb[9] = 8'h10; prio_tb[12] = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refuse();
    t_mid_unlink();
    t_repend_idle();
    t_same_cycle();
    t_not_found();
    t_bottom_unlink();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule